// File: doc/BRIEF.md
# External Data-Memory Access Sequencer

This block drives the external data-RAM bus for an 8051-class core whose machine cycle is a single clock. The core hands it a read or write request with a 16-bit address and, for writes, a data byte. The sequencer runs the access over a fixed set of clock phases. First it puts the address on the bus with an address-latch pulse. Then it asserts the read or write strobe for a programmable stretch. In the final clock it drops the strobe, and for a read it returns the byte captured from the bus together with a one-clock done pulse.

The stretch comes from a 3-bit wait-state register held inside the block. The core reads and writes this register through a special-function-register port at address 0x9F. Each wait state adds one clock, so an access takes 4 to 11 clocks. The block also makes the address-latch pulse for ordinary instructions. The core tells it where each instruction starts, and it emits one half-clock pulse at that point. Back-to-back single-cycle instructions therefore produce a pulse train at the core clock rate.

Top module: `xmem_seq`

## Requirements
- R1: After reset the wait-state register reads 0, and `busy`, `done`, `bus_rd`, `bus_wr` and `ale` are all low.
- R2: A write to SFR address 0x9F stores bits [2:0] of the data and drops bits [7:3]. A read of 0x9F returns the stored value in bits [2:0] with bits [7:3] zero. A write to any other SFR address changes nothing, and a read of any other address returns 0.
- R3: An accepted access keeps `busy` high for exactly 4+n clocks, where n is the wait-state value. `done` is high only in the last of those clocks.
- R4: In clock 1 of an access the address is on `bus_addr` and no strobe is asserted. The strobe is high in clocks 2 through 3+n. It is low again in clock 4+n. `bus_addr` is held through the whole access.
- R5: For a read, `rdata` takes the value of `bus_rdata` sampled at the clock edge that ends clock 3+n. It is valid in the done clock and is held until the next read completes.
- R6: For a write, `bus_wdata` carries the request data for the whole access and only `bus_wr` pulses. `bus_rd` and `bus_wr` are never high together.
- R7: The wait-state value is taken when an access is accepted. A register write during an access applies from the next access onward.
- R8: A request sampled while `busy` is high is ignored. The running access keeps its address, direction and length.
- R9: `ale` is high during the high half of the clock that follows each clock edge at which `ins_start` is high or a request is accepted. It is low at every other time. Starts on consecutive clocks make `ale` toggle at the clock rate.
- R10: A request sampled with `busy` low is accepted at that edge, and clock 1 of the access is the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one machine cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR port address |
| sfr_wr | input | 1 | SFR write enable |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational on `sfr_addr`) |
| req | input | 1 | Access request, sampled at the clock edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | High for the whole access |
| done | output | 1 | One-clock pulse in the last clock of an access |
| rdata | output | 8 | Captured read data |
| ins_start | input | 1 | Instruction-start pulse from the core |
| bus_addr | output | 16 | External address bus |
| bus_wdata | output | 8 | External write data |
| bus_rdata | input | 8 | External read data |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| ale | output | 1 | Address latch enable |

## Verification
The bench targets the extremes of the wait count (0 and 7), where an off-by-one in the end-of-access compare would give a 3-clock or 5-clock zero-wait access. It changes `bus_rdata` every clock, so a design that captures one edge early or late returns the wrong byte. It rewrites the register in the middle of an access to catch a design that reads the live register instead of the value latched at acceptance, and it fires requests, including one held high, into a busy access to catch an accept that corrupts the running address. Finally, it samples `ale` in both clock halves during a run of back-to-back instruction starts: a level-registered pulse would stay high for a whole clock, and a dropped toggle would lose every second pulse.

// File: rtl/xmem_seq.sv
module xmem_seq #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int WSW  = 3,
  parameter int SFRW = 8,
  parameter logic [SFRW-1:0] WS_SFR = 8'h9F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SFRW-1:0] sfr_addr,
  input  logic            sfr_wr,
  input  logic [DW-1:0]   sfr_wdata,
  output logic [DW-1:0]   sfr_rdata,
  input  logic            req,
  input  logic            req_we,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rdata,
  input  logic            ins_start,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic            ale
);

  localparam int CW = $clog2((1 << WSW) + 4);

  logic [WSW-1:0] ws_reg, ws_cur;
  logic [CW-1:0]  cnt;
  logic           busy_q, we_q, ale_p, ale_n;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;

  wire           sfr_hit = (sfr_addr == WS_SFR);
  wire           accept  = req && !busy_q;
  wire [CW-1:0]  ws_ext  = CW'(ws_cur);
  wire           last    = busy_q && (cnt == ws_ext + CW'(3));
  wire           strobe  = busy_q && (cnt != '0) && (cnt <= ws_ext + CW'(2));
  wire           cap     = busy_q && !we_q && (cnt == ws_ext + CW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_reg  <= '0;
      ws_cur  <= '0;
      cnt     <= '0;
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ale_p   <= 1'b0;
    end else begin
      if (sfr_wr && sfr_hit) ws_reg <= sfr_wdata[WSW-1:0];
      if (accept) begin
        busy_q  <= 1'b1;
        cnt     <= '0;
        ws_cur  <= ws_reg;
        we_q    <= req_we;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      cnt    <= cnt + CW'(1);
        if (cap)  rdata_q <= bus_rdata;
      end
      if (ins_start || accept) ale_p <= ~ale_p;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ale_n <= 1'b0;
    else        ale_n <= ale_p;
  end

  assign ale       = ale_p ^ ale_n;
  assign sfr_rdata = sfr_hit ? DW'(ws_reg) : '0;
  assign busy      = busy_q;
  assign done      = last;
  assign rdata     = rdata_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_rd    = strobe && !we_q;
  assign bus_wr    = strobe && we_q;

  AST_SFR_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_hit) |=> (!sfr_hit || sfr_rdata == DW'($past(sfr_wdata[WSW-1:0])))); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R3
  AST_DONE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R3
  AST_STROBE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (busy && !done)); // R4
  AST_FIRST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !(bus_rd || bus_wr)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R6
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(bus_addr) && $stable(bus_wdata))); // R8

endmodule

// File: tb/xmem_seq_tb.sv
module xmem_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic       req = 1'b0, req_we = 1'b0, ins_start = 1'b0;
  logic [15:0] req_addr = 16'h0000;
  logic [7:0] req_wdata = 8'h00, rd_src = 8'h00;
  logic [7:0] sfr_rdata, rdata, bus_wdata;
  logic [15:0] bus_addr;
  logic       busy, done, bus_rd, bus_wr, ale;

  always #10 clk = ~clk;

  xmem_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .ins_start(ins_start), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_src), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .ale(ale)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  string scen = "reset";

  // reference model state
  int  m_wreg = 0, m_ws = 0, m_k = 0;
  bit  m_busy = 0, m_we = 0, m_ale = 0;
  int  m_addr = 0, m_wdata = 0, m_rdata = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t", rq, scen, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit acc;
    acc = req && !m_busy;
    if (m_busy) begin
      if (m_k == m_ws + 3 && !m_we) m_rdata = rd_src;
      if (m_k == m_ws + 4) m_busy = 0;
      else m_k++;
    end else if (acc) begin              // R10: clock 1 follows the accepting edge
      m_busy = 1; m_k = 1; m_ws = m_wreg; // R7: value latched here
      m_we = req_we; m_addr = req_addr; m_wdata = req_wdata;
    end
    if (sfr_wr && sfr_addr == 8'h9F) m_wreg = sfr_wdata & 7;
    m_ale = ins_start || acc;
  endtask

  task automatic compare();
    bit strb;
    int exp_sfr;
    strb = m_busy && m_k >= 2 && m_k <= m_ws + 3;
    exp_sfr = (sfr_addr == 8'h9F) ? m_wreg : 0;
    chk(busy == m_busy, "R3", "busy", busy, m_busy);
    chk(done == (m_busy && m_k == m_ws + 4), "R3", "done", done, m_busy && m_k == m_ws + 4);
    chk(bus_rd == (strb && !m_we), "R4", "bus_rd", bus_rd, strb && !m_we);
    chk(bus_wr == (strb && m_we), "R6", "bus_wr", bus_wr, strb && m_we);
    chk(ale == m_ale, "R9", "ale high half", ale, m_ale);
    chk(rdata == m_rdata[7:0], "R5", "rdata", rdata, m_rdata);
    chk(sfr_rdata == exp_sfr[7:0], "R2", "sfr_rdata", sfr_rdata, exp_sfr);
    if (m_busy) begin
      chk(bus_addr == m_addr[15:0], "R8", "bus_addr", bus_addr, m_addr);
      if (m_we) chk(bus_wdata == m_wdata[7:0], "R6", "bus_wdata", bus_wdata, m_wdata);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #5 compare();
    #10 chk(ale == 1'b0, "R9", "ale low half", ale, 0);
    rd_src = rd_src + 8'h1D;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    tick();
    sfr_wr = 1'b0; sfr_addr = 8'h9F;
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    tick();
    req = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    scen = "watchdog";
    chk(1'b0, "R3", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    sfr_addr = 8'h9F;
    repeat (3) @(posedge clk);
    #15 rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(sfr_rdata == 8'h00, "R1", "wait reg after reset", sfr_rdata, 0);
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(!bus_rd && !bus_wr && !ale, "R1", "strobes/ale after reset", {bus_rd, bus_wr, ale}, 0);
    #4;
    idle(2);

    scen = "R2 sfr";
    sfr_write(8'h9F, 8'hFB);   // keeps 3
    idle(1);
    sfr_write(8'h9E, 8'h05);   // other address: ignored
    sfr_addr = 8'h9E; #1
    chk(sfr_rdata == 8'h00, "R2", "other sfr reads zero", sfr_rdata, 0);
    sfr_addr = 8'h9F; #1
    chk(sfr_rdata == 8'h03, "R2", "wait reg kept", sfr_rdata, 3);
    idle(1);

    scen = "R5 read ws3";
    access(1'b0, 16'h1234, 8'h00);
    idle(9);

    scen = "R6 write ws0";
    sfr_write(8'h9F, 8'h00);
    access(1'b1, 16'hBEEF, 8'hC3);
    idle(5);

    scen = "R7 ws change mid access";
    sfr_write(8'h9F, 8'h07);
    access(1'b0, 16'h00A5, 8'h00);
    idle(2);
    sfr_write(8'h9F, 8'h01);
    idle(10);
    access(1'b0, 16'h5A5A, 8'h00);
    idle(7);

    scen = "R8 req while busy";
    access(1'b1, 16'h2222, 8'h11);
    req = 1'b1; req_we = 1'b0; req_addr = 16'h7777;
    idle(3);
    req = 1'b0;
    idle(4);
    scen = "R8 req held high";
    req = 1'b1; req_we = 1'b0; req_addr = 16'h4321;
    idle(12);
    req = 1'b0;
    idle(6);

    scen = "R9 ale train";
    ins_start = 1'b1;
    idle(5);
    ins_start = 1'b0;
    idle(2);
    ins_start = 1'b1; tick(); ins_start = 1'b0;
    idle(3);

    scen = "R10 read ws7 boundary";
    sfr_write(8'h9F, 8'h07);
    access(1'b0, 16'hFFFF, 8'h00);
    idle(13);

    finish_run();
  end
endmodule